// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers twelve maskable interrupt sources, a software break request and the power-on reset condition. It picks one winner by fixed priority and presents a 16-bit vector address to an 8-bit CPU. Internal sources arrive as single-cycle pulses:

- display-block-done
- vertical sync
- four timer overflows
- serial port
- I2C interface
- a free-running tick that fires every 4096 clocks

Three external pins pass through a synchronizer and a per-pin edge detector. A polarity register selects the active edge of each pin.

Each maskable source has a request latch and an enable bit, and software reaches both through a small register port. The CPU supplies its interrupt-disable flag. When the CPU pulses the acknowledge input, the block latches the current vector, clears the winning request and pulses a request to set the disable flag. Stacking of program counter and status is left to the CPU.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every request bit, enable bit and polarity bit reads 0, `ack_vector` is 0000, and a reset vector is pending: `irq_pending`=1 and `irq_vector`=FFFE until the first acknowledge, which returns FFFE.
- R2: Maskable sources have a fixed priority, from highest to lowest, with these vectors:

  | Priority index | Source | Vector |
  |---|---|---|
  | 0 | display-done | FFFC |
  | 1 | pin 1 | FFFA |
  | 2 | pin 0 | FFF8 |
  | 3 | timer 4 (`tmr_ovf[3]`) | FFF4 |
  | 4 | tick | FFF2 |
  | 5 | vsync | FFF0 |
  | 6 | timer 3 | FFEE |
  | 7 | timer 2 | FFEC |
  | 8 | timer 1 (`tmr_ovf[0]`) | FFEA |
  | 9 | serial | FFE8 |
  | 10 | I2C | FFE6 |
  | 11 | pin 2 | FFE4 |

  FFF6 is never produced.
- R3: A maskable source contributes to `irq_pending` only when its request bit is 1, its enable bit is 1 and `cpu_iflag` is 0.
- R4: When `irq_ack` is high while `irq_pending` is high, `set_iflag` is high in that same cycle. `ack_vector` then holds that cycle's `irq_vector` from the next edge on, and the winning request is cleared.
- R5: Request registers are at address 0 (bits 7:0 hold priority indices 0..7) and address 1 (bits 3:0 hold indices 8..11; other bits read 0). Writing 0 to a request bit clears it, and writing 1 leaves it unchanged.
- R6: Enable registers are at address 2 and address 3, using the same bit layout as the request registers. They read back exactly what was written.
- R7: A pulse on `brk_req` raises a break request that ignores the enable bits and `cpu_iflag`. It has the lowest priority, its vector is FFDE, and acknowledging it clears it.
- R8: The polarity register is at address 4, and only bits 3, 4 and 5 are stored. These bits select the edge for pins 0, 1 and 2 (0 = rising, 1 = falling). A selected edge sets the request once, on the third clock edge after the pin changes. A held level and the opposite edge set nothing.
- R9: The tick source sets its request (index 4) once every 4096 clock cycles.
- R10: If a hardware set event and a software clear write reach the same request bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_iflag | input | 1 | CPU interrupt-disable flag |
| irq_ack | input | 1 | CPU accept pulse |
| brk_req | input | 1 | Software break request pulse |
| disp_done_pulse | input | 1 | Display-block-done event |
| vsync_pulse | input | 1 | Vertical sync event |
| tmr_ovf | input | 4 | Timer overflow events, bit 0 = timer 1 |
| ser_pulse | input | 1 | Serial port event |
| i2c_pulse | input | 1 | I2C interface event |
| ext_pin | input | 3 | External interrupt pins 0..2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_pending | output | 1 | Some source is ready to be taken |
| irq_vector | output | 16 | Vector of the current winner |
| ack_vector | output | 16 | Vector latched at the last accept |
| set_iflag | output | 1 | Request to set the CPU disable flag |

## Verification
The hardest case to reach is a hardware set event and a software clear landing on the same request bit in the same clock. The bench drives a timer pulse and a zero write to the request register in the same low clock phase, so both meet at one edge. The tick interval is measured by clearing the tick request as soon as it is seen and counting cycles until it returns. External pins are checked on both edges with the polarity switched in between, including a held level and an edge of the wrong direction.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_MASK = 12;
  localparam int IDX_W    = 4;

  localparam logic [15:0] VEC_RESET = 16'hFFFE;
  localparam logic [15:0] VEC_BRK   = 16'hFFDE;

  typedef enum logic [2:0] {
    ADR_REQ_LO = 3'd0,
    ADR_REQ_HI = 3'd1,
    ADR_EN_LO  = 3'd2,
    ADR_EN_HI  = 3'd3,
    ADR_POL    = 3'd4
  } reg_addr_e;

  // priority index of each maskable source (0 = highest)
  localparam int SRC_DISP  = 0;
  localparam int SRC_PIN1  = 1;
  localparam int SRC_PIN0  = 2;
  localparam int SRC_TMR4  = 3;
  localparam int SRC_TICK  = 4;
  localparam int SRC_VSYNC = 5;
  localparam int SRC_TMR3  = 6;
  localparam int SRC_TMR2  = 7;
  localparam int SRC_TMR1  = 8;
  localparam int SRC_SER   = 9;
  localparam int SRC_I2C   = 10;
  localparam int SRC_PIN2  = 11;

  function automatic logic [15:0] mask_vector(input logic [IDX_W-1:0] idx);
    logic [15:0] v;
    case (idx)
      4'd0:    v = 16'hFFFC;
      4'd1:    v = 16'hFFFA;
      4'd2:    v = 16'hFFF8;
      4'd3:    v = 16'hFFF4;  // FFF6 left unused
      4'd4:    v = 16'hFFF2;
      4'd5:    v = 16'hFFF0;
      4'd6:    v = 16'hFFEE;
      4'd7:    v = 16'hFFEC;
      4'd8:    v = 16'hFFEA;
      4'd9:    v = 16'hFFE8;
      4'd10:   v = 16'hFFE6;
      default: v = 16'hFFE4;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge #(
  parameter int N_PINS      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] fall_sel,
  output logic [N_PINS-1:0] edge_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    // chain[0..SYNC_STAGES-1] synchronizer, chain[SYNC_STAGES] previous level
    logic [SYNC_STAGES:0] chain_q, chain_d;

    always_comb chain_d = {chain_q[SYNC_STAGES-1:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    always_comb begin
      if (fall_sel[g]) edge_o[g] = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
      else             edge_o[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

    // one level change yields one event while the polarity stays put
    assert_edge_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o[g] |=> (!$stable(fall_sel[g]) || !edge_o[g]));
  end
endmodule

// File: rtl/irqc_tick.sv
module irqc_tick #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/irqc_req_bank.sv
module irqc_req_bank
  import irqc_pkg::*;
#(
  parameter int N      = NUM_MASK,
  parameter int N_PINS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      set_ev,
  input  logic [N-1:0]      clr_ack,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [N-1:0]      req_q,
  output logic [N-1:0]      en_q,
  output logic [N_PINS-1:0] fall_sel
);
  localparam int HI_W    = N - 8;
  localparam int POL_LSB = 3;

  logic [N-1:0]      req_d, en_d, sw_keep;
  logic [N_PINS-1:0] pol_q, pol_d;

  always_comb begin
    sw_keep = '1;
    en_d    = en_q;
    pol_d   = pol_q;
    if (wr) begin
      case (reg_addr_e'(addr))
        ADR_REQ_LO: sw_keep[7:0]    = wdata;
        ADR_REQ_HI: sw_keep[N-1:8]  = wdata[HI_W-1:0];
        ADR_EN_LO:  en_d[7:0]       = wdata;
        ADR_EN_HI:  en_d[N-1:8]     = wdata[HI_W-1:0];
        ADR_POL:    pol_d           = wdata[POL_LSB+N_PINS-1:POL_LSB];
        default: ;
      endcase
    end
    // hardware set dominates both software clear and accept clear
    req_d = set_ev | (req_q & sw_keep & ~clr_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
      pol_q <= pol_d;
    end
  end

  assign fall_sel = pol_q;

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADR_REQ_LO: rdata = req_q[7:0];
      ADR_REQ_HI: rdata[HI_W-1:0] = req_q[N-1:8];
      ADR_EN_LO:  rdata = en_q[7:0];
      ADR_EN_HI:  rdata[HI_W-1:0] = en_q[N-1:8];
      ADR_POL:    rdata[POL_LSB+N_PINS-1:POL_LSB] = pol_q;
      default: ;
    endcase
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_sw_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q[k]) |-> $past(set_ev[k]));
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[k] |=> req_q[k]);
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ack[k] && !set_ev[k]) |=> !req_q[k]);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int TICK_DIV    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_iflag,
  input  logic        irq_ack,
  input  logic        brk_req,
  input  logic        disp_done_pulse,
  input  logic        vsync_pulse,
  input  logic [3:0]  tmr_ovf,
  input  logic        ser_pulse,
  input  logic        i2c_pulse,
  input  logic [2:0]  ext_pin,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_pending,
  output logic [15:0] irq_vector,
  output logic [15:0] ack_vector,
  output logic        set_iflag
);
  localparam int N      = NUM_MASK;
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] pin_edge, fall_sel;
  logic              tick;
  logic [N-1:0]      set_ev, clr_ack, req_q, en_q, ready;
  logic              win_any, take;
  logic [IDX_W-1:0]  win_idx;
  logic              rst_pend_q, rst_pend_d;
  logic              brk_q, brk_d;
  logic [15:0]       ack_vec_q, ack_vec_d;

  irqc_pin_edge #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .fall_sel(fall_sel), .edge_o(pin_edge));

  irqc_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick));

  always_comb begin
    set_ev            = '0;
    set_ev[SRC_DISP]  = disp_done_pulse;
    set_ev[SRC_PIN1]  = pin_edge[1];
    set_ev[SRC_PIN0]  = pin_edge[0];
    set_ev[SRC_TMR4]  = tmr_ovf[3];
    set_ev[SRC_TICK]  = tick;
    set_ev[SRC_VSYNC] = vsync_pulse;
    set_ev[SRC_TMR3]  = tmr_ovf[2];
    set_ev[SRC_TMR2]  = tmr_ovf[1];
    set_ev[SRC_TMR1]  = tmr_ovf[0];
    set_ev[SRC_SER]   = ser_pulse;
    set_ev[SRC_I2C]   = i2c_pulse;
    set_ev[SRC_PIN2]  = pin_edge[2];
  end

  irqc_req_bank #(.N(N), .N_PINS(N_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ack(clr_ack),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .req_q(req_q), .en_q(en_q), .fall_sel(fall_sel));

  // winner search: lowest index among ready sources
  always_comb begin
    ready   = req_q & en_q & {N{~cpu_iflag}};
    win_any = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready[i]) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    irq_pending = rst_pend_q | win_any | brk_q;
    if (rst_pend_q)   irq_vector = VEC_RESET;
    else if (win_any) irq_vector = mask_vector(win_idx);
    else if (brk_q)   irq_vector = VEC_BRK;
    else              irq_vector = '0;
    take      = irq_ack & irq_pending;
    set_iflag = take;
    clr_ack   = '0;
    if (take && !rst_pend_q && win_any) clr_ack[win_idx] = 1'b1;
    rst_pend_d = rst_pend_q & ~take;
    brk_d      = brk_req | (brk_q & ~(take & ~rst_pend_q & ~win_any));
    ack_vec_d  = take ? irq_vector : ack_vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      brk_q      <= 1'b0;
      ack_vec_q  <= '0;
    end else begin
      rst_pend_q <= rst_pend_d;
      brk_q      <= brk_d;
      ack_vec_q  <= ack_vec_d;
    end
  end

  assign ack_vector = ack_vec_q;

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && cpu_iflag) |-> (irq_vector == VEC_RESET || irq_vector == VEC_BRK));
  assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_ack));
  assert_latch_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ack_vector == $past(irq_vector)));
  assert_brk_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vector == VEC_BRK && !brk_req) |=> !brk_q);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, cpu_iflag, irq_ack, brk_req, disp_done_pulse, vsync_pulse;
  logic [3:0]  tmr_ovf;
  logic        ser_pulse, i2c_pulse;
  logic [2:0]  ext_pin;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        irq_pending, set_iflag;
  logic [15:0] irq_vector, ack_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_iflag(cpu_iflag), .irq_ack(irq_ack), .brk_req(brk_req),
    .disp_done_pulse(disp_done_pulse), .vsync_pulse(vsync_pulse), .tmr_ovf(tmr_ovf),
    .ser_pulse(ser_pulse), .i2c_pulse(i2c_pulse), .ext_pin(ext_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pending(irq_pending), .irq_vector(irq_vector), .ack_vector(ack_vector),
    .set_iflag(set_iflag));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic take_ack(input string rq, input logic [15:0] exp_vec);
    @(negedge clk);
    chk(rq, irq_pending, 1);
    chk(rq, irq_vector, exp_vec);
    irq_ack = 1'b1;
    #1 chk(rq, set_iflag, 1);
    @(negedge clk);
    irq_ack = 1'b0;
    chk(rq, ack_vector, exp_vec);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst_n = 1'b0; cpu_iflag = 1'b1; irq_ack = 1'b0; brk_req = 1'b0;
    disp_done_pulse = 1'b0; vsync_pulse = 1'b0; tmr_ovf = '0; ser_pulse = 1'b0;
    i2c_pulse = 1'b0; ext_pin = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 regs zero", d, 0);
    end
    chk("R1 ack_vector", ack_vector, 16'h0000);
    chk("R1 pending", irq_pending, 1);
    take_ack("R1 reset vector", 16'hFFFE);
    #1 chk("R1 reset gone", irq_pending, 0);
  endtask

  task automatic t_sw_access;
    logic [7:0] d;
    wr(3'd2, 8'hA5); rd(3'd2, d); chk("R6 en_lo A5", d, 8'hA5);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R6 en_hi", d, 8'h0F);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); rd(3'd2, d); chk("R6 en_lo 0", d, 0);
    @(negedge clk); tmr_ovf[0] = 1'b1; @(negedge clk); tmr_ovf[0] = 1'b0;
    rd(3'd1, d); chk("R5 req_hi set", d, 8'h01);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R5 write 1 keeps", d, 8'h01);
    wr(3'd1, 8'hFE); rd(3'd1, d); chk("R5 write 0 clears", d, 8'h00);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R5 no sw set", d & 8'hEF, 8'h00);
  endtask

  task automatic t_masking;
    logic [7:0] d;
    @(negedge clk); tmr_ovf[0] = 1'b1; @(negedge clk); tmr_ovf[0] = 1'b0;
    cpu_iflag = 1'b0; #1 chk("R3 enable 0", irq_pending, 0);
    wr(3'd3, 8'h01); cpu_iflag = 1'b1; #1 chk("R3 iflag 1", irq_pending, 0);
    cpu_iflag = 1'b0; #1 chk("R3 all three", irq_pending, 1);
    take_ack("R3 timer1 vector", 16'hFFEA);
    rd(3'd1, d); chk("R4 request cleared", d, 8'h00);
    chk("R4 nothing left", irq_pending, 0);
  endtask

  task automatic t_priority;
    wr(3'd2, 8'hEF); wr(3'd3, 8'h0F);
    @(negedge clk);
    disp_done_pulse = 1'b1; vsync_pulse = 1'b1; tmr_ovf = 4'hF; ser_pulse = 1'b1; i2c_pulse = 1'b1;
    @(negedge clk);
    disp_done_pulse = 1'b0; vsync_pulse = 1'b0; tmr_ovf = 4'h0; ser_pulse = 1'b0; i2c_pulse = 1'b0;
    take_ack("R2 disp", 16'hFFFC);
    take_ack("R2 timer4", 16'hFFF4);
    take_ack("R2 vsync", 16'hFFF0);
    take_ack("R2 timer3", 16'hFFEE);
    take_ack("R2 timer2", 16'hFFEC);
    take_ack("R2 timer1", 16'hFFEA);
    take_ack("R2 serial", 16'hFFE8);
    take_ack("R2 i2c", 16'hFFE6);
    #1 chk("R2 drained", irq_pending, 0);
  endtask

  task automatic t_brk;
    cpu_iflag = 1'b1;
    @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    chk("R7 brk ignores iflag", irq_pending, 1);
    chk("R7 brk vector", irq_vector, 16'hFFDE);
    cpu_iflag = 1'b0;
    @(negedge clk); tmr_ovf[0] = 1'b1; @(negedge clk); tmr_ovf[0] = 1'b0;
    take_ack("R7 maskable before brk", 16'hFFEA);
    take_ack("R7 brk last", 16'hFFDE);
    #1 chk("R7 brk cleared", irq_pending, 0);
  endtask

  task automatic t_set_vs_clear;
    logic [7:0] d;
    @(negedge clk);
    tmr_ovf[1] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
    @(negedge clk);
    tmr_ovf[1] = 1'b0; reg_wr = 1'b0;
    rd(3'd0, d); chk("R10 set wins", d & 8'hEF, 8'h80);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_pins;
    logic [7:0] d;
    cpu_iflag = 1'b0;
    @(negedge clk); ext_pin[0] = 1'b1;
    wait_n(2); rd(3'd0, d); chk("R8 not before third edge", d & 8'h04, 0);
    wait_n(1); rd(3'd0, d); chk("R8 pin0 rising", d & 8'h04, 8'h04);
    take_ack("R8 pin0 vector", 16'hFFF8);
    wait_n(5); rd(3'd0, d); chk("R8 held level once", d & 8'h04, 0);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R8 pol readback", d, 8'h38);
    wr(3'd4, 8'h08);
    @(negedge clk); ext_pin[0] = 1'b0;
    wait_n(3); rd(3'd0, d); chk("R8 pin0 falling", d & 8'h04, 8'h04);
    wr(3'd0, 8'hFB);
    @(negedge clk); ext_pin[1] = 1'b1;
    wait_n(3); take_ack("R8 pin1 rising vector", 16'hFFFA);
    wr(3'd4, 8'h20);
    @(negedge clk); ext_pin[2] = 1'b1;
    wait_n(4); rd(3'd1, d); chk("R8 pin2 wrong edge", d, 0);
    @(negedge clk); ext_pin[2] = 1'b0;
    wait_n(3); rd(3'd1, d); chk("R8 pin2 falling", d, 8'h08);
    take_ack("R8 pin2 vector", 16'hFFE4);
  endtask

  task automatic t_tick;
    logic [7:0] d;
    int k;
    cpu_iflag = 1'b1;
    k = 0;
    do begin @(negedge clk); rd(3'd0, d); k++; end while (!d[4] && k < 9000);
    chk("R9 tick seen", d[4], 1);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hEF;
    k = 0;
    do begin
      @(negedge clk); reg_wr = 1'b0; k++;
      rd(3'd0, d);
    end while (!d[4] && k < 9000);
    chk("R9 tick period", k, 4096);
  endtask

  initial begin
    t_reset();
    t_sw_access();
    t_masking();
    t_priority();
    t_brk();
    t_set_vs_clear();
    t_pins();
    t_tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule